// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block moves a processor's working context to and from a byte-wide stack around interrupt service. When an entry request is accepted, it copies the program counter, both index registers, both accumulators and the condition code register from its inputs. It then writes them to memory one byte per clock, starting at the current stack pointer and working downward. Once the condition code byte is in memory, it raises the interrupt mask bits. Finally it reads a 16-bit handler address from the vector page at the top of the address space and loads it into the program counter.

A return command runs the same path in reverse. The block reads the nine bytes back, condition code first and program counter low byte last, and restores every register. This includes the mask bits as they were before entry. Instruction decoding and choosing which source wins belong to the surrounding core. The requester supplies the vector slot and says whether the request comes from the non-maskable pin.

Top module: `irq_ctx_seq`

## Requirements
- R1: While idle, an entry request (`start`) is accepted only when `insn_done` (instruction boundary) or `urgent` (reset or non-maskable request) is high in the same cycle; otherwise it has no effect and `busy` stays low.
- R2: Entry writes nine bytes. The write addresses and contents are: PC[7:0] at SP, PC[15:8] at SP-1, IY[7:0] at SP-2, IY[15:8] at SP-3, IX[7:0] at SP-4, IX[15:8] at SP-5, A at SP-6, B at SP-7, CCR at SP-8. `sp_out` ends at SP-9.
- R3: At most one memory transfer happens per clock. Each push writes at the current stack pointer and then decrements it.
- R4: The condition code byte is stacked with its pre-entry value. After it is stacked, CCR bit 4 (I mask) is set in `ccr_out`.
- R5: When `xirq` is high on an accepted entry, CCR bit 6 (X mask) is set as well as bit 4. Otherwise bit 6 keeps its input value.
- R6: The handler address is read from 16'hFFC0 + 2*`vec_idx`: the high byte from that even address, then the low byte from the next odd address. It is loaded into `pc_out`. Slot 25 is the maskable external pin at 16'hFFF2.
- R7: A return command (`ret`) while idle reads nine bytes. Each read first increments SP and then reads. The bytes are restored in the order CCR, B, A, IX[15:8], IX[7:0], IY[15:8], IY[7:0], PC[15:8], PC[7:0]. The I and X bits return to their stacked values, and `sp_out` ends at the start SP plus 9.
- R8: `busy` is high from the cycle after acceptance through the cycle `done` is high. `done` is a one-cycle pulse. It comes 13 clocks after an accepted entry and 11 clocks after an accepted return, and all register outputs are final while it is high.
- R9: A `start` seen while `busy` is high is ignored. The operation in progress neither restarts nor changes its stacked data.
- R10: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Entry request |
| insn_done | input | 1 | Current instruction has completed |
| urgent | input | 1 | Request needs no instruction boundary (reset or non-maskable) |
| xirq | input | 1 | Request comes from the non-maskable pin; also set X |
| vec_idx | input | 5 | Vector slot of the winning source |
| ret | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Program counter to save |
| ix_in | input | 16 | Index register X to save |
| iy_in | input | 16 | Index register Y to save |
| a_in | input | 8 | Accumulator A to save |
| b_in | input | 8 | Accumulator B to save |
| ccr_in | input | 8 | Condition code register to save |
| sp_in | input | 16 | Stack pointer at the start of either operation |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data is returned on the next clock |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter result |
| ix_out | output | 16 | Index register X result |
| iy_out | output | 16 | Index register Y result |
| a_out | output | 8 | Accumulator A result |
| b_out | output | 8 | Accumulator B result |
| ccr_out | output | 8 | Condition code result |
| sp_out | output | 16 | Stack pointer result |

## Verification
Several errors would show up as a single misplaced byte, so the bench reads back every stack location after each entry. This catches a reversed push order, a stacked CCR that already has the mask set, and an off-by-one stack pointer, which would leave the last byte over the caller's data. A return from non-maskable entry must clear both I and X again; a design that kept the masks would never take another interrupt. Requests without a boundary must do nothing, and a start pulse arriving in the middle of an entry must not restart the sequence or overwrite the stacked data. The high and low vector bytes are given different values, so a design that swapped them would load the wrong handler address.

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq #(
  parameter logic [15:0] VEC_BASE = 16'hFFC0,
  parameter int          VIW      = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           insn_done,
  input  logic           urgent,
  input  logic           xirq,
  input  logic [VIW-1:0] vec_idx,
  input  logic           ret,
  input  logic [15:0]    pc_in,
  input  logic [15:0]    ix_in,
  input  logic [15:0]    iy_in,
  input  logic [7:0]     a_in,
  input  logic [7:0]     b_in,
  input  logic [7:0]     ccr_in,
  input  logic [15:0]    sp_in,
  output logic [15:0]    mem_addr,
  output logic           mem_we,
  output logic           mem_re,
  output logic [7:0]     mem_wdata,
  input  logic [7:0]     mem_rdata,
  output logic           busy,
  output logic           done,
  output logic [15:0]    pc_out,
  output logic [15:0]    ix_out,
  output logic [15:0]    iy_out,
  output logic [7:0]     a_out,
  output logic [7:0]     b_out,
  output logic [7:0]     ccr_out,
  output logic [15:0]    sp_out
);
  localparam int NBYTES = 9;
  localparam logic [3:0] LAST = 4'(NBYTES - 1);

  typedef enum logic [1:0] {IDLE, PUSH, VEC, PULL} phase_t;

  phase_t         phase;
  logic [3:0]     cnt;
  logic           xset;
  logic [VIW-1:0] vidx;
  logic [3:0]     slot;

  assign busy   = (phase != IDLE) || done;
  assign mem_we = (phase == PUSH);
  assign mem_re = (phase == VEC && cnt != 4'd2) || (phase == PULL && cnt != 4'(NBYTES));
  assign slot   = 4'(NBYTES) - cnt;

  always_comb begin
    case (phase)
      PUSH:    mem_addr = sp_out;
      VEC:     mem_addr = VEC_BASE + 16'({vidx, cnt[0]});
      default: mem_addr = sp_out + 16'd1;
    endcase
    case (cnt)
      4'd0:    mem_wdata = pc_out[7:0];
      4'd1:    mem_wdata = pc_out[15:8];
      4'd2:    mem_wdata = iy_out[7:0];
      4'd3:    mem_wdata = iy_out[15:8];
      4'd4:    mem_wdata = ix_out[7:0];
      4'd5:    mem_wdata = ix_out[15:8];
      4'd6:    mem_wdata = a_out;
      4'd7:    mem_wdata = b_out;
      default: mem_wdata = ccr_out;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE; cnt <= '0; done <= 1'b0; xset <= 1'b0; vidx <= '0;
      pc_out <= '0; ix_out <= '0; iy_out <= '0;
      a_out <= '0; b_out <= '0; ccr_out <= '0; sp_out <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (!done) begin
          if (start && (insn_done || urgent)) begin
            pc_out <= pc_in; ix_out <= ix_in; iy_out <= iy_in;
            a_out <= a_in; b_out <= b_in; ccr_out <= ccr_in; sp_out <= sp_in;
            xset <= xirq; vidx <= vec_idx;
            phase <= PUSH; cnt <= '0;
          end else if (ret) begin
            sp_out <= sp_in;
            phase <= PULL; cnt <= '0;
          end
        end
        PUSH: begin
          sp_out <= sp_out - 16'd1;
          if (cnt == LAST) begin
            ccr_out[4] <= 1'b1;
            if (xset) ccr_out[6] <= 1'b1;
            phase <= VEC; cnt <= '0;
          end else cnt <= cnt + 4'd1;
        end
        VEC: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd1) pc_out[15:8] <= mem_rdata;
          if (cnt == 4'd2) begin
            pc_out[7:0] <= mem_rdata;
            done <= 1'b1; phase <= IDLE;
          end
        end
        PULL: begin
          cnt <= cnt + 4'd1;
          if (cnt != 4'(NBYTES)) sp_out <= sp_out + 16'd1;
          else begin done <= 1'b1; phase <= IDLE; end
          if (cnt != 4'd0) begin
            case (slot)
              4'd0:    pc_out[7:0]  <= mem_rdata;
              4'd1:    pc_out[15:8] <= mem_rdata;
              4'd2:    iy_out[7:0]  <= mem_rdata;
              4'd3:    iy_out[15:8] <= mem_rdata;
              4'd4:    ix_out[7:0]  <= mem_rdata;
              4'd5:    ix_out[15:8] <= mem_rdata;
              4'd6:    a_out        <= mem_rdata;
              4'd7:    b_out        <= mem_rdata;
              default: ccr_out      <= mem_rdata;
            endcase
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        insn_done,
  input logic        urgent,
  input logic        ret,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] sp_out
);
  p_one_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 16'd1));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_no_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !insn_done && !urgent && !ret) |=> !busy);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> !$fell(busy) || $past(done));
endmodule

bind irq_ctx_seq irq_ctx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .insn_done(insn_done),
  .urgent(urgent), .ret(ret), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_re(mem_re), .sp_out(sp_out)
);

// File: tb/irq_ctx_seq_bench.sv
`timescale 1ns/1ps
module irq_ctx_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, insn_done = 0, urgent = 0, xirq = 0, ret = 0;
  logic [4:0]  vec_idx = '0;
  logic [15:0] pc_in = '0, ix_in = '0, iy_in = '0, sp_in = '0;
  logic [7:0]  a_in = '0, b_in = '0, ccr_in = '0;
  logic [15:0] mem_addr, pc_out, ix_out, iy_out, sp_out;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem_wdata, a_out, b_out, ccr_out;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  mem [0:1023];
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  irq_ctx_seq u_irq_ctx_seq (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_until_done(output int n, output bit busy_ok);
    n = 0; busy_ok = 1;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
      start = 0; ret = 0;
      if (!busy) busy_ok = 0;
    end while (!done && n < 40);
  endtask

  task automatic t_reset;
    check("R10 busy", 16'(busy), 0);
    check("R10 done", 16'(done), 0);
  endtask

  task automatic t_no_boundary;
    @(negedge clk);
    start = 1; insn_done = 0; urgent = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 no boundary busy", 16'(busy), 0);
    end
    start = 0;
  endtask

  task automatic t_entry(input logic [15:0] pc, ix, iy, sp,
                         input logic [7:0] a, b, ccr,
                         input logic [4:0] idx, input bit xi, urg,
                         input logic [15:0] vec, input logic [7:0] ccr_exp);
    int n; bit bok;
    @(negedge clk);
    pc_in = pc; ix_in = ix; iy_in = iy; sp_in = sp;
    a_in = a; b_in = b; ccr_in = ccr; vec_idx = idx;
    xirq = xi; urgent = urg; insn_done = !urg; start = 1;
    run_until_done(n, bok);
    insn_done = 0; urgent = 0; xirq = 0;
    check("R8 entry cycles", 16'(n), 13);
    check("R8 busy held", 16'(bok), 1);
    check("R2 PCL", 16'(mem[sp[9:0]]), 16'(pc[7:0]));
    check("R2 PCH", 16'(mem[10'(sp - 1)]), 16'(pc[15:8]));
    check("R2 IYL", 16'(mem[10'(sp - 2)]), 16'(iy[7:0]));
    check("R2 IYH", 16'(mem[10'(sp - 3)]), 16'(iy[15:8]));
    check("R2 IXL", 16'(mem[10'(sp - 4)]), 16'(ix[7:0]));
    check("R2 IXH", 16'(mem[10'(sp - 5)]), 16'(ix[15:8]));
    check("R2 A", 16'(mem[10'(sp - 6)]), 16'(a));
    check("R2 B", 16'(mem[10'(sp - 7)]), 16'(b));
    check("R4 stacked CCR", 16'(mem[10'(sp - 8)]), 16'(ccr));
    check("R3 untouched below", 16'(mem[10'(sp - 9)]), 16'(8'(10'(sp - 9)) ^ 8'h5A));
    check("R2 sp_out", sp_out, sp - 16'd9);
    check("R6 vector pc", pc_out, vec);
    check("R5 ccr_out", 16'(ccr_out), 16'(ccr_exp));
    check("R2 ix kept", ix_out, ix);
    @(negedge clk);
    check("R8 done pulse", 16'(done), 0);
    check("R8 busy released", 16'(busy), 0);
  endtask

  task automatic t_return(input logic [15:0] sp, pc, ix, iy,
                          input logic [7:0] a, b, ccr);
    int n; bit bok;
    @(negedge clk);
    pc_in = '0; ix_in = '0; iy_in = '0; a_in = '0; b_in = '0; ccr_in = 8'hFF;
    sp_in = sp; ret = 1;
    run_until_done(n, bok);
    check("R7 return cycles", 16'(n), 11);
    check("R7 busy held", 16'(bok), 1);
    check("R7 pc", pc_out, pc);
    check("R7 ix", ix_out, ix);
    check("R7 iy", iy_out, iy);
    check("R7 a", 16'(a_out), 16'(a));
    check("R7 b", 16'(b_out), 16'(b));
    check("R7 ccr masks restored", 16'(ccr_out), 16'(ccr));
    check("R7 sp", sp_out, sp + 16'd9);
    @(negedge clk);
    check("R8 done pulse after return", 16'(done), 0);
  endtask

  task automatic t_busy_start;
    int n;
    @(negedge clk);
    pc_in = 16'hBEEF; ix_in = 16'h0102; iy_in = 16'h0304; sp_in = 16'h0180;
    a_in = 8'h05; b_in = 8'h06; ccr_in = 8'h00; vec_idx = 5'd25;
    insn_done = 1; start = 1;
    @(negedge clk); start = 0; n = 1;
    repeat (4) begin @(negedge clk); n++; end
    pc_in = 16'h7777; sp_in = 16'h0100; start = 1;
    @(negedge clk); n++; start = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    insn_done = 0;
    check("R9 no restart", 16'(n), 13);
    check("R9 stacked PCL", 16'(mem[10'h180]), 16'h00EF);
    check("R9 stacked PCH", 16'(mem[10'h17F]), 16'h00BE);
    check("R9 sp_out", sp_out, 16'h0177);
    @(negedge clk);
    check("R9 dropped request", 16'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
    mem[10'h3F2] = 8'h12; mem[10'h3F3] = 8'h34;
    mem[10'h3F4] = 8'hAB; mem[10'h3F5] = 8'hCD;
    mem[10'h3C0] = 8'h80; mem[10'h3C1] = 8'h01;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_boundary();
    t_entry(16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h01FF, 8'h11, 8'h22, 8'h00,
            5'd25, 0, 0, 16'h1234, 8'h10);
    t_return(16'h01F6, 16'hA1B2, 16'hC3D4, 16'hE5F6, 8'h11, 8'h22, 8'h00);
    t_entry(16'h4455, 16'h6677, 16'h8899, 16'h0150, 8'h3C, 8'hC3, 8'h05,
            5'd26, 1, 1, 16'hABCD, 8'h55);
    t_return(16'h0147, 16'h4455, 16'h6677, 16'h8899, 8'h3C, 8'hC3, 8'h05);
    t_entry(16'h0F0F, 16'h1111, 16'h2222, 16'h0120, 8'h00, 8'hFF, 8'hC1,
            5'd0, 0, 0, 16'h8001, 8'hD1);
    t_busy_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule